// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host a byte-wide window into packet page memory. The memory holds four pages of 2048 bytes each. A 16-bit pointer register selects the location. The host loads the pointer one byte at a time, then moves data through a four-byte window. Bit 15 of the pointer picks the page source. When it is set, the page comes from the head of the receive queue. When it is clear, the page comes from the packet-number value. Both page numbers arrive on input ports, because the queues themselves live outside this block.

Bit 14 of the pointer picks the addressing mode. In auto-increment mode, every data access uses the current pointer offset and then advances the 11-bit offset field by one. In fixed mode, the pointer does not move and the window offset (0 to 3) is added to the pointer offset instead. All reads, whether of the pointer or of memory, pass through one small state machine. It has two states. ST_IDLE means no read is in flight. ST_FETCH means a read was issued on the previous edge and its result is captured on this edge. A read strobe moves the machine to ST_FETCH from either state. An edge without a read returns it to ST_IDLE.

Top module: `pkt_data_port`

## Requirements
- R1: Reset clears the pointer to 0x0000 and holds `host_rvalid` and `host_rdata` at zero.
- R2: A write to address 0 loads pointer bits [7:0] and a write to address 1 loads bits [15:8]; each write leaves the other byte unchanged.
- R3: A read of address 0 returns pointer bits [7:0]; a read of address 1 returns bits [15:8] ANDed with 0xF7, so pointer bit 11 always reads back as 0.
- R4: Data accesses target the page on `rxq_head_page` when pointer bit 15 is 1, and the page on `pkt_num_page` when it is 0.
- R5: With pointer bit 14 clear, a data access at address 4+k (k = 0..3) targets byte (pointer[10:0] + k) mod 2048, and the pointer is left unchanged.
- R6: With pointer bit 14 set, a data access targets byte pointer[10:0] and ignores k. Afterwards pointer[10:0] advances by one and wraps from 0x7FF to 0, while bits [15:11] keep their value.
- R7: A read strobe sampled on clock edge n gives `host_rvalid` high with valid `host_rdata` after edge n+1, for one cycle.
- R8: A byte written through the data window is returned by a later read of the same page and byte.
- R9: Addresses 2 and 3 read as 0x00, and writes to them change neither the pointer nor the memory.
- R10: When `host_rd` and `host_wr` are high together, the write is performed and the read is dropped: no `host_rvalid` follows.
- R11: Read strobes on consecutive cycles give `host_rvalid` on consecutive cycles, with the results in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Host byte address: 0/1 pointer low/high, 2/3 unmapped, 4..7 data window |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while `host_rvalid` is high |
| host_rvalid | output | 1 | Read result strobe |
| rxq_head_page | input | PG_W (2) | Page number at the head of the receive queue |
| pkt_num_page | input | PG_W (2) | Page number from the packet-number value |

## Verification
Two events can land in the same cycle. The capture of an earlier read result can coincide with a new data access that moves the pointer. A write and a read can also be strobed together. The bench holds the read strobe high for three consecutive cycles in auto-increment mode. It then expects three consecutive result bytes in pointer order, which shows that the pointer advance does not disturb the result still in flight. It also strobes both read and write in the same cycle, in random and directed patterns. In that case it expects the written byte to appear in later reads, the pointer to advance when auto-increment is set, and no result strobe to follow.

// File: rtl/pkt_port_pkg.sv
`timescale 1ns/1ps
package pkt_port_pkg;

    localparam int HOST_AW      = 3;
    localparam int PTR_W        = 16;
    localparam int PAGE_SRC_BIT = 15;
    localparam int AUTO_INC_BIT = 14;
    localparam int LANES        = 4;
    localparam int LANE_W       = 2;

    localparam logic [HOST_AW-1:0] ADDR_PTR_LO = 3'd0;
    localparam logic [HOST_AW-1:0] ADDR_PTR_HI = 3'd1;
    localparam logic [7:0]         PTR_HI_RD_MASK = 8'hF7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } port_state_e;

    typedef struct packed {
        logic              ptr_lo;
        logic              ptr_hi;
        logic              window;
        logic [LANE_W-1:0] win_off;
    } host_dec_t;

    function automatic host_dec_t decode_host(input logic [HOST_AW-1:0] a);
        host_dec_t d;
        d.ptr_lo  = (a == ADDR_PTR_LO);
        d.ptr_hi  = (a == ADDR_PTR_HI);
        d.window  = a[HOST_AW-1];
        d.win_off = a[LANE_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/pkt_ptr_reg.sv
`timescale 1ns/1ps
module pkt_ptr_reg
    import pkt_port_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wbyte,
    input  logic             step,
    output logic [PTR_W-1:0] ptr_o
);

    logic [PTR_W-1:0] ptr_q;

    // Byte loads and the offset step never coincide: they decode from
    // different host addresses.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (wr_lo) begin
            ptr_q[7:0] <= wbyte;
        end else if (wr_hi) begin
            ptr_q[PTR_W-1:8] <= wbyte;
        end else if (step) begin
            ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/pkt_addr_gen.sv
`timescale 1ns/1ps
module pkt_addr_gen
    import pkt_port_pkg::*;
#(
    parameter int PG_W  = 2,
    parameter int OFF_W = 11,
    localparam int WORD_AW = PG_W + OFF_W - LANE_W
) (
    input  logic               page_from_rxq,
    input  logic               auto_inc,
    input  logic [OFF_W-1:0]   base_off,
    input  logic [LANE_W-1:0]  win_off,
    input  logic [PG_W-1:0]    rxq_page,
    input  logic [PG_W-1:0]    pkn_page,
    output logic [WORD_AW-1:0] word_idx,
    output logic [LANE_W-1:0]  lane
);

    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] byte_off;

    always_comb begin
        page     = page_from_rxq ? rxq_page : pkn_page;
        // Window offset only applies in fixed mode; sum wraps in the field.
        byte_off = auto_inc ? base_off : (base_off + OFF_W'(win_off));
        word_idx = {page, byte_off[OFF_W-1:LANE_W]};
        lane     = byte_off[LANE_W-1:0];
    end

endmodule

// File: rtl/pkt_page_ram.sv
`timescale 1ns/1ps
module pkt_page_ram
    import pkt_port_pkg::*;
#(
    parameter int WORDS = 2048,
    localparam int AW   = $clog2(WORDS),
    localparam int DW   = 8 * LANES
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wbyte,
    output logic [DW-1:0]     q
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane == LANE_W'(l)) begin
                    mem[addr][l*8 +: 8] <= wbyte;
                end
            end
        end
        if (re) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/pkt_data_port.sv
`timescale 1ns/1ps
module pkt_data_port
    import pkt_port_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PG_W    = $clog2(NUM_PAGES),
    localparam int OFF_W   = $clog2(PAGE_BYTES),
    localparam int WORD_AW = PG_W + OFF_W - LANE_W,
    localparam int WORDS   = NUM_PAGES * PAGE_BYTES / LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               host_rvalid,
    input  logic [PG_W-1:0]    rxq_head_page,
    input  logic [PG_W-1:0]    pkt_num_page
);

    host_dec_t        dec;
    logic             wr_fire, rd_fire, win_acc;
    logic [PTR_W-1:0] ptr_q;
    logic [WORD_AW-1:0] word_idx;
    logic [LANE_W-1:0]  lane;
    logic [8*LANES-1:0] ram_q;
    logic [7:0]       reg_view, lane_byte;

    port_state_e      state_q, state_d;
    logic [LANE_W-1:0] lane_q;
    logic             from_ram_q;
    logic [7:0]       reg_hold_q;

    // Write wins when both strobes arrive together.
    always_comb begin
        dec     = decode_host(host_addr);
        wr_fire = host_wr;
        rd_fire = host_rd && !host_wr;
        win_acc = (wr_fire || rd_fire) && dec.window;
    end

    pkt_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (wr_fire && dec.ptr_lo),
        .wr_hi (wr_fire && dec.ptr_hi),
        .wbyte (host_wdata),
        .step  (win_acc && ptr_q[AUTO_INC_BIT]),
        .ptr_o (ptr_q)
    );

    pkt_addr_gen #(.PG_W(PG_W), .OFF_W(OFF_W)) u_agen (
        .page_from_rxq (ptr_q[PAGE_SRC_BIT]),
        .auto_inc      (ptr_q[AUTO_INC_BIT]),
        .base_off      (ptr_q[OFF_W-1:0]),
        .win_off       (dec.win_off),
        .rxq_page      (rxq_head_page),
        .pkn_page      (pkt_num_page),
        .word_idx      (word_idx),
        .lane          (lane)
    );

    pkt_page_ram #(.WORDS(WORDS)) u_ram (
        .clk   (clk),
        .we    (wr_fire && dec.window),
        .re    (rd_fire && dec.window),
        .addr  (word_idx),
        .lane  (lane),
        .wbyte (host_wdata),
        .q     (ram_q)
    );

    always_comb begin
        if (dec.ptr_lo) begin
            reg_view = ptr_q[7:0];
        end else if (dec.ptr_hi) begin
            reg_view = ptr_q[PTR_W-1:8] & PTR_HI_RD_MASK;
        end else begin
            reg_view = 8'h00;
        end
    end

    assign lane_byte = ram_q[{lane_q, 3'b000} +: 8];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = rd_fire ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_d = rd_fire ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Issue-side capture of read context
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q     <= '0;
            from_ram_q <= 1'b0;
            reg_hold_q <= 8'h00;
        end else if (rd_fire) begin
            lane_q     <= lane;
            from_ram_q <= dec.window;
            reg_hold_q <= reg_view;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= 8'h00;
        end else begin
            host_rvalid <= (state_q == ST_FETCH);
            if (state_q == ST_FETCH) begin
                host_rdata <= from_ram_q ? lane_byte : reg_hold_q;
            end
        end
    end

endmodule

// File: rtl/pkt_data_port_chk.sv
`timescale 1ns/1ps
module pkt_data_port_chk
    import pkt_port_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input logic               clk,
    input logic               rst,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic               host_rvalid,
    input logic [PTR_W-1:0]   ptr
);

    logic rd_ok, win_acc;
    assign rd_ok   = host_rd && !host_wr;
    assign win_acc = (host_rd || host_wr) && host_addr[HOST_AW-1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ptr == '0 && !host_rvalid && host_rdata == 8'h00));

    // R2
    ptr_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_PTR_LO) |=>
        (ptr[7:0] == $past(host_wdata) && ptr[15:8] == $past(ptr[15:8])));

    // R2
    ptr_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_PTR_HI) |=>
        (ptr[15:8] == $past(host_wdata) && ptr[7:0] == $past(ptr[7:0])));

    // R3
    hi_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && $past(rd_ok && host_addr == ADDR_PTR_HI, 2)) |->
        (host_rdata[3] == 1'b0));

    // R5
    fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (win_acc && !ptr[AUTO_INC_BIT]) |=> $stable(ptr));

    // R6
    auto_step_chk: assert property (@(posedge clk) disable iff (rst)
        (win_acc && ptr[AUTO_INC_BIT]) |=>
        (ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1'b1) &&
         ptr[15:OFF_W] == $past(ptr[15:OFF_W])));

    // R7
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ok |=> ##1 host_rvalid);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && $past(rd_ok && (host_addr == 3'd2 || host_addr == 3'd3), 2)) |->
        (host_rdata == 8'h00));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_wr) |=> ##1 !host_rvalid);

    // R11
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(rd_ok, 2));

endmodule

bind pkt_data_port pkt_data_port_chk #(.OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ptr         (ptr_q)
);

// File: tb/pkt_data_port_tb.sv
`timescale 1ns/1ps
module pkt_data_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [1:0] rxq_head_page = '0;
    logic [1:0] pkt_num_page = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_ptr;
    logic [7:0]  m_mem [int];

    always #4 clk = ~clk;

    pkt_data_port dut_i (
        .clk           (clk),
        .rst           (rst),
        .host_addr     (host_addr),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .host_rvalid   (host_rvalid),
        .rxq_head_page (rxq_head_page),
        .pkt_num_page  (pkt_num_page)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic int exp_index(input logic [15:0] p, input logic [1:0] k);
        logic [1:0]  pg;
        logic [10:0] b;
        pg = p[15] ? rxq_head_page : pkt_num_page;
        b  = p[14] ? p[10:0] : (p[10:0] + 11'(k));
        return int'(pg) * 2048 + int'(b);
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (a == 3'd0) return m_ptr[7:0];
        if (a == 3'd1) return m_ptr[15:8] & 8'hF7;
        if (a[2]) return m_mem[exp_index(m_ptr, a[1:0])];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd0) m_ptr[7:0] = d;
        else if (a == 3'd1) m_ptr[15:8] = d;
        else if (a[2]) begin
            m_mem[exp_index(m_ptr, a[1:0])] = d;
            if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
        @(negedge clk);
        host_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [2:0] a, input string tag);
        logic [7:0] e;
        e = exp_read(a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
        @(negedge clk);
        host_rd = 1'b0;
        if (a[2] && m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
        @(negedge clk);
        check(host_rvalid == 1'b1, "R7 rvalid", int'(host_rvalid), 1);
        check(host_rdata == e, tag, int'(host_rdata), int'(e));
    endtask

    task automatic bus_both(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        model_write(a, d);
        @(negedge clk);
        check(host_rvalid == 1'b0, "R10 no rvalid", int'(host_rvalid), 0);
    endtask

    task automatic set_ptr(input logic [15:0] v);
        bus_write(3'd1, v[15:8]);
        bus_write(3'd0, v[7:0]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] e0, e1, e2;
        void'($urandom(32'd4242));
        m_ptr = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(host_rvalid == 1'b0, "R1 rvalid", int'(host_rvalid), 0);
        check(host_rdata == 8'h00, "R1 rdata", int'(host_rdata), 0);
        bus_read(3'd0, "R1 ptr lo");
        bus_read(3'd1, "R1 ptr hi");

        // Fill every page in auto-increment mode (R6: window offset ignored)
        for (int p = 0; p < 4; p++) begin
            pkt_num_page = 2'(p);
            set_ptr(16'h4000);
            for (int i = 0; i < 2048; i++) begin
                bus_write(3'(4 + ($urandom % 4)), 8'((p * 37) ^ (i * 7) ^ (i >> 3)));
            end
            // R6 wrap back to 0 with upper bits kept
            bus_read(3'd0, "R6 wrap lo");
            bus_read(3'd1, "R6 wrap hi");
        end

        // R4 page selection by pointer bit 15
        pkt_num_page = 2'd0; rxq_head_page = 2'd3;
        set_ptr(16'h0005);
        bus_write(3'd4, 8'h11);
        set_ptr(16'h8005);
        bus_write(3'd4, 8'h33);
        bus_read(3'd4, "R4 rx page");
        set_ptr(16'h0005);
        bus_read(3'd4, "R4 pkt page");

        // R5 fixed mode offset wraps inside the page; R3 bit 11 masked
        pkt_num_page = 2'd1;
        set_ptr(16'h0FFF);
        bus_write(3'd7, 8'hA5);
        bus_read(3'd1, "R3 hi mask");
        bus_read(3'd0, "R5 ptr unchanged");
        set_ptr(16'h0002);
        bus_read(3'd4, "R5 wrapped byte");
        bus_read(3'd6, "R8 readback");

        // R9 unmapped addresses
        bus_write(3'd2, 8'hFF);
        bus_write(3'd3, 8'hEE);
        bus_read(3'd0, "R9 ptr lo kept");
        bus_read(3'd1, "R9 ptr hi kept");
        bus_read(3'd2, "R9 read zero");
        bus_read(3'd3, "R9 read zero");

        // R10 collision in auto mode: write done, pointer advanced
        set_ptr(16'h4010);
        bus_both(3'd5, 8'h5A);
        bus_read(3'd0, "R10 ptr stepped");
        set_ptr(16'h0010);
        bus_read(3'd4, "R10 write kept");

        // R11 back-to-back reads in auto mode
        rxq_head_page = 2'd2;
        set_ptr(16'hC100);
        e0 = m_mem[2 * 2048 + 16'h100];
        e1 = m_mem[2 * 2048 + 16'h101];
        e2 = m_mem[2 * 2048 + 16'h102];
        @(negedge clk);
        host_addr = 3'd4; host_rd = 1'b1;
        @(negedge clk);
        check(host_rvalid == 1'b0, "R11 not yet", int'(host_rvalid), 0);
        @(negedge clk);
        check(host_rvalid && host_rdata == e0, "R11 first", int'(host_rdata), int'(e0));
        @(negedge clk);
        host_rd = 1'b0;
        check(host_rvalid && host_rdata == e1, "R11 second", int'(host_rdata), int'(e1));
        @(negedge clk);
        check(host_rvalid && host_rdata == e2, "R11 third", int'(host_rdata), int'(e2));
        @(negedge clk);
        check(host_rvalid == 1'b0, "R11 ends", int'(host_rvalid), 0);
        m_ptr[10:0] = m_ptr[10:0] + 11'd3;
        bus_read(3'd0, "R11 ptr advanced");

        // Constrained random mix (R2 R3 R5 R6 R8 R9 R10)
        for (int n = 0; n < 400; n++) begin
            int op;
            rxq_head_page = 2'($urandom);
            pkt_num_page  = 2'($urandom);
            op = $urandom % 10;
            case (op)
                0: bus_write(3'd0, 8'($urandom));
                1: bus_write(3'd1, 8'($urandom));
                2, 3: bus_write(3'(4 + ($urandom % 4)), 8'($urandom));
                4, 5: bus_read(3'(4 + ($urandom % 4)), "R8 random data");
                6: bus_read(3'd0, "R2 random ptr lo");
                7: bus_read(3'd1, "R3 random ptr hi");
                8: bus_write(3'(2 + ($urandom % 2)), 8'($urandom));
                default: bus_both(3'(4 + ($urandom % 4)), 8'($urandom));
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule